// File: doc/BRIEF.md
# Clock Policy Victim Frame Selector

This block keeps per-frame bookkeeping for a fixed pool of physical page frames and names the frame to evict when a page fault needs room. Every frame carries a valid flag and a referenced flag. A reference strobe with a frame index marks that frame as recently used. A replacement request returns one victim frame index together with a one-cycle valid pulse.

While some frames have never been loaded, a request is answered at once with the lowest-numbered empty frame, and the hand does not move. Once every frame is loaded, a circular hand walks the frames one per clock. A frame whose referenced flag is set has the flag cleared and is passed over, so it gets a second chance. The first frame found with a clear flag becomes the victim, and the hand moves one step past it. The page loaded into the victim's slot is then the newest page in circular order.

The replacement request uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops while a sweep is in progress, and the requester must hold its request until it is taken. The victim output is a plain pulse with no back-pressure: the consumer must take `vic_idx` in the cycle `vic_valid` is high. The reference strobe is a plain control input and is never stalled.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset no frame is valid, every referenced flag is 0, the hand points at frame 0, `req_ready` is 1 and `vic_valid` is 0.
- R2: A clock edge with `ref_valid` high sets the referenced flag of frame `ref_idx`. The flag is still set after any clear or fill that happens at the same edge.
- R3: A request taken while any frame is invalid returns the lowest-numbered invalid frame. That frame becomes valid and its referenced flag is cleared. `vic_valid` rises in the cycle after the accepting edge. The hand does not move and no sweep takes place.
- R4: A request taken with all frames valid starts a sweep. `req_ready` is 0 from the next cycle until the cycle in which `vic_valid` is high. A `req_valid` held high during that time is not taken and produces no extra victim.
- R5: During a sweep, the frame at the hand is chosen when its referenced flag is 0. The victim index is reported with `vic_valid` in the following cycle, and the hand moves one step, wrapping from NFRAMES-1 to 0.
- R6: During a sweep, a frame at the hand whose referenced flag is 1 has the flag cleared, and the hand moves one step. Exactly one frame is examined per clock.
- R7: When all flags are set and no reference arrives during the sweep, the victim is the frame the hand pointed at when the request was taken. `vic_valid` is high NFRAMES+1 edges after the accepting edge.
- R8: A reference at the same edge as the clear of that frame leaves its flag set. The frame therefore survives the next pass of the hand.
- R9: The victim index is held stable for as long as `vic_valid` is high, and each taken request yields exactly one victim pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference strobe |
| ref_idx | input | $clog2(NFRAMES) | Index of the referenced frame |
| req_valid | input | 1 | Replacement request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| vic_valid | output | 1 | One-cycle victim pulse |
| vic_idx | output | $clog2(NFRAMES) | Selected victim frame |

## Verification
The two functions that can fall in the same cycle are a reference strobe and a sweep step that clears the same frame's flag. The same collision can also occur between a reference and a fill of that frame. A directed case references the frame under the hand in the first sweep cycle. It then expects that frame to survive a full revolution, so that the victim becomes the next frame instead. In the random phase, references and requests overlap freely. There, a per-cycle reference model applies the sweep or fill first and the reference last, then predicts the pulse, the index and `req_ready`.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_t;
endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NFRAMES = 8,
  localparam int IW = $clog2(NFRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_valid,
  input  logic [IW-1:0]      ref_idx,
  input  logic               clr_en,
  input  logic [IW-1:0]      clr_idx,
  input  logic               fill_en,
  input  logic [IW-1:0]      fill_idx,
  output logic [NFRAMES-1:0] rbits,
  output logic [NFRAMES-1:0] vbits
);
  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    logic hit_ref, hit_clr, hit_fill;
    assign hit_ref  = ref_valid && (ref_idx == IW'(g));
    assign hit_clr  = clr_en && (clr_idx == IW'(g));
    assign hit_fill = fill_en && (fill_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rbits[g] <= 1'b0;
        vbits[g] <= 1'b0;
      end else begin
        rbits[g] <= (rbits[g] && !hit_clr && !hit_fill) || hit_ref;
        vbits[g] <= vbits[g] || hit_fill;
      end
    end
  end
endmodule

// File: rtl/free_finder.sv
module free_finder #(
  parameter int NFRAMES = 8,
  localparam int IW = $clog2(NFRAMES)
) (
  input  logic [NFRAMES-1:0] vbits,
  output logic               any_free,
  output logic [IW-1:0]      free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NFRAMES - 1; i >= 0; i--) begin
      if (!vbits[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import clkrep_pkg::*;
#(
  parameter int NFRAMES = 8,
  localparam int IW = $clog2(NFRAMES),
  localparam logic [IW-1:0] LAST = IW'(NFRAMES - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               any_free,
  input  logic [IW-1:0]      free_idx,
  input  logic [NFRAMES-1:0] rbits,
  output logic               req_ready,
  output logic               fill_en,
  output logic               clr_en,
  output logic               busy,
  output logic [IW-1:0]      hand,
  output logic               vic_valid,
  output logic [IW-1:0]      vic_idx
);
  sweep_state_t state;
  logic accept, found;
  logic [IW-1:0] hand_nx;

  assign busy      = (state == ST_SWEEP);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign fill_en   = accept && any_free;
  assign clr_en    = busy && rbits[hand];
  assign found     = busy && !rbits[hand];
  assign hand_nx   = (hand == LAST) ? '0 : hand + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hand      <= '0;
      vic_valid <= 1'b0;
      vic_idx   <= '0;
    end else begin
      vic_valid <= fill_en || found;
      if (fill_en)    vic_idx <= free_idx;
      else if (found) vic_idx <= hand;
      if (busy) hand <= hand_nx;
      case (state)
        ST_IDLE:  if (accept && !any_free) state <= ST_SWEEP;
        ST_SWEEP: if (found) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
  parameter int NFRAMES = 8,
  localparam int IW = $clog2(NFRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_valid,
  input  logic [IW-1:0] ref_idx,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          vic_valid,
  output logic [IW-1:0] vic_idx
);
  logic [NFRAMES-1:0] rbits, vbits;
  logic any_free, fill_en, clr_en, busy;
  logic [IW-1:0] free_idx, hand;

  ref_bit_array #(.NFRAMES(NFRAMES)) u_bits (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .clr_en(clr_en), .clr_idx(hand), .fill_en(fill_en), .fill_idx(free_idx),
    .rbits(rbits), .vbits(vbits)
  );

  free_finder #(.NFRAMES(NFRAMES)) u_free (
    .vbits(vbits), .any_free(any_free), .free_idx(free_idx)
  );

  sweep_ctrl #(.NFRAMES(NFRAMES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .any_free(any_free),
    .free_idx(free_idx), .rbits(rbits), .req_ready(req_ready),
    .fill_en(fill_en), .clr_en(clr_en), .busy(busy), .hand(hand),
    .vic_valid(vic_valid), .vic_idx(vic_idx)
  );
endmodule

// File: rtl/clock_victim_picker_chk.sv
module clock_victim_picker_chk #(
  parameter int NFRAMES = 8,
  localparam int IW = $clog2(NFRAMES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_valid,
  input logic [IW-1:0]      ref_idx,
  input logic               req_valid,
  input logic               req_ready,
  input logic               vic_valid,
  input logic [IW-1:0]      vic_idx,
  input logic [NFRAMES-1:0] rbits,
  input logic               any_free,
  input logic               busy,
  input logic [IW-1:0]      hand
);
  logic [IW+1:0] sweep_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy || ref_valid) sweep_cnt <= '0;
    else sweep_cnt <= sweep_cnt + 1'b1;
  end

  // R1: the cycle after reset shows no victim pulse and an open request port
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!vic_valid && req_ready));

  // R2: a reference always leaves its frame flagged
  a_r2_ref_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> rbits[$past(ref_idx)]);

  // R3: a fill answers in the next cycle and does not move the hand
  a_r3_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && any_free) |=> (vic_valid && $stable(hand)));

  // R4: a request that finds no free frame closes the port
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !any_free) |=> !req_ready);

  // R6: each sweep cycle moves the hand by exactly one frame
  a_r6_hand_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (hand == (($past(hand) == IW'(NFRAMES - 1)) ? '0 : $past(hand) + 1'b1)));

  // R5: a sweep ends on a frame whose flag was clear
  a_r5_victim_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rbits[hand]) |=> (vic_valid && vic_idx == $past(hand)));

  // R7: without references a sweep examines at most NFRAMES+1 frames
  a_r7_sweep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sweep_cnt <= (IW+2)'(NFRAMES)));
endmodule

bind clock_victim_picker clock_victim_picker_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
  .req_valid(req_valid), .req_ready(req_ready), .vic_valid(vic_valid),
  .vic_idx(vic_idx), .rbits(rbits), .any_free(any_free), .busy(busy), .hand(hand)
);

// File: tb/clock_victim_picker_test.sv
module clock_victim_picker_test;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n, ref_valid, req_valid, req_ready, vic_valid;
  logic [IW-1:0] ref_idx, vic_idx;

  always #2 clk = ~clk;

  clock_victim_picker #(.NFRAMES(N)) uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .req_valid(req_valid), .req_ready(req_ready), .vic_valid(vic_valid),
    .vic_idx(vic_idx)
  );

  int n_checks = 0, n_errors = 0;
  bit m_r[N], m_v[N];
  int m_hand = 0;
  bit m_busy = 0, ev = 0;
  int ei = 0;

  task automatic check(string req, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic cyc(string tag);
    int f;
    ev = 0;
    if (!m_busy && req_valid) begin
      f = lowest_free();
      if (f >= 0) begin
        m_v[f] = 1; m_r[f] = 0; ev = 1; ei = f;
      end else m_busy = 1;
    end else if (m_busy) begin
      if (!m_r[m_hand]) begin ev = 1; ei = m_hand; m_busy = 0; end
      else m_r[m_hand] = 0;
      m_hand = (m_hand + 1) % N;
    end
    if (ref_valid) m_r[ref_idx] = 1;
    @(posedge clk); #1;
    check({tag, " pulse"}, vic_valid == ev, vic_valid, ev);
    if (ev) check({tag, " index"}, vic_idx == IW'(ei), vic_idx, ei);
    check({tag, " ready"}, req_ready == !m_busy, req_ready, !m_busy);
  endtask

  task automatic ref_all();
    req_valid = 0;
    for (int i = 0; i < N; i++) begin
      ref_valid = 1; ref_idx = IW'(i); cyc("R2");
    end
    ref_valid = 0;
  endtask

  // one request, returns victim and number of edges after the accepting one
  task automatic one_request(string tag, output int vic, output int lat);
    req_valid = 1; cyc(tag); req_valid = 0;
    lat = 0;
    while (!vic_valid && lat < 4 * N) begin cyc(tag); lat++; end
    vic = vic_idx;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check("watchdog", 0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int vic, lat;
    void'($urandom(32'd5417));
    rst_n = 0; ref_valid = 0; req_valid = 0; ref_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 ready", req_ready == 1, req_ready, 1);
    check("R1 pulse", vic_valid == 0, vic_valid, 0);

    // R3: a stray reference to an empty frame, then eight fills in index order
    ref_valid = 1; ref_idx = 3; cyc("R2"); ref_valid = 0;
    for (int i = 0; i < N; i++) begin
      req_valid = 1; cyc("R3");
      check("R3 fill order", vic_valid && vic_idx == IW'(i), vic_idx, i);
    end
    req_valid = 0;

    // R5: all flags clear, victim is frame 0 one edge after the sweep starts
    one_request("R5", vic, lat);
    check("R5 victim", vic == 0, vic, 0);
    check("R5 latency", lat == 1, lat, 1);

    // R7: all flags set, a full revolution returns to frame 1
    ref_all();
    one_request("R7", vic, lat);
    check("R7 victim", vic == 1, vic, 1);
    check("R7 latency", lat == N + 1, lat, N + 1);

    // R8: reference to the frame under the hand in its clear cycle
    ref_all();
    req_valid = 1; cyc("R8");
    ref_valid = 1; ref_idx = 2; cyc("R8"); ref_valid = 0;
    // R4: keep requesting while the sweep runs
    lat = 1;
    while (!vic_valid && lat < 4 * N) begin cyc("R4"); lat++; end
    check("R8 survivor skipped", vic_idx == 3, vic_idx, 3);
    req_valid = 0;
    cyc("R9");
    check("R4 no extra victim", vic_valid == 0 || ev, vic_valid, ev);

    // random phase, checked by the per-cycle model
    for (int k = 0; k < 3000; k++) begin
      ref_valid = ($urandom_range(0, 99) < 35);
      ref_idx   = IW'($urandom_range(0, N - 1));
      req_valid = ($urandom_range(0, 99) < 25);
      cyc("R6");
    end
    ref_valid = 0; req_valid = 0;
    cyc("R9");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule